// File: doc/BRIEF.md
# Low-Power Clock State Controller

This block decides whether a processing core is running, parked in stop-grant, or asleep, and drives the enables that follow from that choice. A level request from the bus side moves the core from running into stop-grant. An active-low sleep request is honoured only once the core is already in stop-grant. Once asleep, the core's clocks to all units are stopped and only the PLL is kept alive. Snoops and interrupts presented while asleep are masked and never reported to the core.

The sleep request arrives from outside the clock domain and passes through a synchroniser of configurable depth before the state machine sees it. The clock enable, the PLL keep-alive flag and the event mask are all registered, and they change on the same edge as the state. Snoop and interrupt pulses are passed on one cycle later, gated by the state current at the time they were sampled. Reset is synchronous and active low.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the next outputs are: state_o = 2'b00 (running), clk_en_o = 1, pll_keep_o = 0, evt_mask_o = 0, irq_take_o = 0, snoop_take_o = 0. This holds from any state, including sleep.
- R2: In running, stopgnt_req_i high at an edge moves state_o to 2'b01 (stop-grant) on that edge.
- R3: A sleep request (sleep_req_n_i low) seen while running has no effect: the state stays 2'b00 and clk_en_o stays 1.
- R4: The sleep request passes through SYNC_STAGES flops. In stop-grant, once the synchronised request is active, the next edge moves state_o to 2'b10 (sleep). A request driven low just before edge k is acted on at edge k+SYNC_STAGES.
- R5: clk_en_o is 0 and pll_keep_o is 1 exactly while state_o is 2'b10. In every other state, clk_en_o is 1 and pll_keep_o is 0.
- R6: evt_mask_o is 1 exactly while asleep. irq_take_o and snoop_take_o go high the cycle after irq_i or snoop_i is high, but only if the state in the sampling cycle was not sleep.
- R7: In sleep, stopgnt_req_i and the event inputs have no effect on the state. Only deassertion of the synchronised sleep request (or reset) moves it, and then always to stop-grant.
- R8: In stop-grant, with stopgnt_req_i low and the synchronised sleep request inactive, the next edge returns the state to running. If the synchronised sleep request is active, sleep wins over the return to running.
- R9: clk_en_o never changes on an edge where state_o does not change.
- R10: state_o never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stopgnt_req_i | input | 1 | Stop-grant request level |
| sleep_req_n_i | input | 1 | Asynchronous sleep request, active low |
| irq_i | input | 1 | Interrupt event pulse |
| snoop_i | input | 1 | Snoop event pulse |
| state_o | output | 2 | Current state: 00 running, 01 stop-grant, 10 sleep |
| clk_en_o | output | 1 | Clock-gate enable for core and bus units |
| pll_keep_o | output | 1 | High while only the PLL is kept running |
| evt_mask_o | output | 1 | High while snoops and interrupts are blocked |
| irq_take_o | output | 1 | Interrupt recognised (one cycle after irq_i) |
| snoop_take_o | output | 1 | Snoop recognised (one cycle after snoop_i) |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. This lengthens the gap between a sleep request changing at the pin and the state reacting, so the reference model's delay queue is exercised at a depth other than the default. That gap also lets the bench place a request-drop and a synchronised sleep request on the same stop-grant edge, which tests that sleep takes priority. Event pulses are issued in running, stop-grant and sleep, so the one-cycle recognition path is compared both masked and unmasked.

// File: rtl/psc_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the low-power clock state controller.
// Assumes two bits are enough for the three states; code 2'b11 is unused.
package psc_pkg;
    typedef enum logic [1:0] {
        PS_RUN     = 2'b00,
        PS_STOPGNT = 2'b01,
        PS_SLEEP   = 2'b10
    } psc_state_t;

    localparam int unsigned PSC_N_EVT = 2;
endpackage

// File: rtl/psc_sync.sv
`timescale 1ns/1ps
// Module: psc_sync
// Multi-flop synchroniser for a single asynchronous level.
// Assumes the input is a slow level (no pulses shorter than a few clocks).
// Resets every stage to RST_VAL.
module psc_sync #(
    parameter int unsigned STAGES  = 2,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_multi
            // Purpose: shift the level through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/psc_fsm.sv
`timescale 1ns/1ps
// Module: psc_fsm
// Three-state low-power controller. It computes the next state and registers
// the state together with the clock enable, the PLL keep-alive flag and the
// event mask, so all four outputs move on the same edge.
// Assumes sleep_req_i is already synchronised and active high.
module psc_fsm
    import psc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stopgnt_req_i,
    input  logic       sleep_req_i,
    output psc_state_t state_o,
    output logic       clk_en_o,
    output logic       pll_keep_o,
    output logic       evt_mask_o
);
    psc_state_t state_q, state_d;
    logic       clk_en_q, pll_keep_q, mask_q;
    logic       sleep_next;

    // Purpose: next-state decision; sleep is only reachable from stop-grant.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_RUN:     if (stopgnt_req_i)       state_d = PS_STOPGNT;
            PS_STOPGNT: if (sleep_req_i)         state_d = PS_SLEEP;
                        else if (!stopgnt_req_i) state_d = PS_RUN;
            PS_SLEEP:   if (!sleep_req_i)        state_d = PS_STOPGNT;
            default:                             state_d = PS_RUN;
        endcase
    end

    assign sleep_next = (state_d == PS_SLEEP);

    // Purpose: register state and all enables from the next-state value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PS_RUN;
            clk_en_q   <= 1'b1;
            pll_keep_q <= 1'b0;
            mask_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            clk_en_q   <= !sleep_next;
            pll_keep_q <= sleep_next;
            mask_q     <= sleep_next;
        end
    end

    assign state_o    = state_q;
    assign clk_en_o   = clk_en_q;
    assign pll_keep_o = pll_keep_q;
    assign evt_mask_o = mask_q;
endmodule

// File: rtl/psc_evt_gate.sv
`timescale 1ns/1ps
// Module: psc_evt_gate
// Registers each event input, blocked while the mask is high.
// Assumes events are single-cycle pulses in the core clock domain.
module psc_evt_gate #(
    parameter int unsigned N_EVT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_i,
    input  logic [N_EVT-1:0] evt_i,
    output logic [N_EVT-1:0] take_o
);
    generate
        for (genvar g = 0; g < N_EVT; g++) begin : g_evt
            logic take_q;
            // Purpose: recognise one event line unless masked.
            always_ff @(posedge clk) begin
                if (!rst_n) take_q <= 1'b0;
                else        take_q <= evt_i[g] & ~mask_i;
            end
            assign take_o[g] = take_q;
        end
    endgenerate
endmodule

// File: rtl/pwr_state_ctrl.sv
`timescale 1ns/1ps
// Module: pwr_state_ctrl (top)
// Low-power clock state controller: running, stop-grant and sleep.
// Assumes sleep_req_n_i is asynchronous and active low, stopgnt_req_i and the
// event pulses are synchronous to clk, and reset is synchronous active low.
module pwr_state_ctrl
    import psc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stopgnt_req_i,
    input  logic       sleep_req_n_i,
    input  logic       irq_i,
    input  logic       snoop_i,
    output logic [1:0] state_o,
    output logic       clk_en_o,
    output logic       pll_keep_o,
    output logic       evt_mask_o,
    output logic       irq_take_o,
    output logic       snoop_take_o
);
    logic                 sleep_n_sync;
    psc_state_t           state;
    logic                 mask;
    logic [PSC_N_EVT-1:0] evt_vec, take_vec;

    psc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sleep_req_n_i),
        .q_o   (sleep_n_sync)
    );

    psc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stopgnt_req_i (stopgnt_req_i),
        .sleep_req_i   (~sleep_n_sync),
        .state_o       (state),
        .clk_en_o      (clk_en_o),
        .pll_keep_o    (pll_keep_o),
        .evt_mask_o    (mask)
    );

    assign evt_vec = {snoop_i, irq_i};

    psc_evt_gate #(.N_EVT(PSC_N_EVT)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_i (mask),
        .evt_i  (evt_vec),
        .take_o (take_vec)
    );

    assign state_o      = state;
    assign evt_mask_o   = mask;
    assign irq_take_o   = take_vec[0];
    assign snoop_take_o = take_vec[1];
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
`timescale 1ns/1ps
// Module: pwr_state_ctrl_chk
// Property checker bound to pwr_state_ctrl; observes top-level ports only.
module pwr_state_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state_o,
    input logic       clk_en_o,
    input logic       pll_keep_o,
    input logic       evt_mask_o,
    input logic       irq_take_o,
    input logic       snoop_take_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (state_o == 2'b00 && clk_en_o && !pll_keep_o && !evt_mask_o));

    assert_no_sleep_from_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'b00 |=> state_o != 2'b10);

    assert_clk_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_o == (state_o != 2'b10)) && (pll_keep_o == (state_o == 2'b10)));

    assert_no_event_in_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_mask_o |=> (!irq_take_o && !snoop_take_o));

    assert_sleep_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'b10 |=> state_o != 2'b00);

    assert_clk_no_glitch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clk_en_o) |-> !$stable(state_o));

    assert_state_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b11);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_o      (state_o),
    .clk_en_o     (clk_en_o),
    .pll_keep_o   (pll_keep_o),
    .evt_mask_o   (evt_mask_o),
    .irq_take_o   (irq_take_o),
    .snoop_take_o (snoop_take_o)
);

// File: tb/tb_pwr_state_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared on every clock, plus directed
// checks at chosen waypoints.
module tb_pwr_state_ctrl;
    localparam int S = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stopgnt = 1'b0, sleep_n = 1'b1, irq = 1'b0, snoop = 1'b0;
    logic [1:0] state;
    logic clk_en, pll_keep, mask, irq_take, snoop_take;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwr_state_ctrl #(.SYNC_STAGES(S)) dut (
        .clk(clk), .rst_n(rst_n), .stopgnt_req_i(stopgnt), .sleep_req_n_i(sleep_n),
        .irq_i(irq), .snoop_i(snoop), .state_o(state), .clk_en_o(clk_en),
        .pll_keep_o(pll_keep), .evt_mask_o(mask), .irq_take_o(irq_take),
        .snoop_take_o(snoop_take)
    );

    // Reference model: a delay queue for the sleep pin, integer state.
    bit sq[$];
    int m_state = 0;
    bit m_irq = 0, m_snp = 0;
    bit m_valid = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            sq = {};
            for (int i = 0; i < S; i++) sq.push_back(1'b1);
            m_state = 0; m_irq = 0; m_snp = 0; m_valid = 1;
        end else begin
            bit slp;
            int nxt;
            slp   = !sq[S-1];
            m_irq = irq && (m_state != 2);
            m_snp = snoop && (m_state != 2);
            nxt = m_state;
            if (m_state == 0 && stopgnt) nxt = 1;
            else if (m_state == 1) begin
                if (slp) nxt = 2;
                else if (!stopgnt) nxt = 0;
            end else if (m_state == 2 && !slp) nxt = 1;
            m_state = nxt;
            sq.push_front(sleep_n);
            void'(sq.pop_back());
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            check("R10 state", state, m_state);
            check("R5 clk_en", clk_en, m_state != 2);
            check("R5 pll_keep", pll_keep, m_state == 2);
            check("R6 mask", mask, m_state == 2);
            check("R6 irq_take", irq_take, m_irq);
            check("R6 snoop_take", snoop_take, m_snp);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        check("R1 reset state", state, 0);
        check("R1 reset clk_en", clk_en, 1);
        rst_n = 1'b1;
        // Interrupt in running is recognised next cycle.
        irq = 1; step(1); irq = 0;
        check("R6 irq taken in run", irq_take, 1);
        // Sleep request in running is ignored.
        sleep_n = 0; step(S + 3);
        check("R3 state after sleep req in run", state, 0);
        check("R3 clk_en after sleep req in run", clk_en, 1);
        sleep_n = 1; step(S + 1);
        // Enter stop-grant.
        stopgnt = 1; step(1);
        check("R2 stop-grant entry", state, 1);
        snoop = 1; step(1); snoop = 0;
        check("R6 snoop taken in stop-grant", snoop_take, 1);
        // Enter sleep after synchroniser delay.
        sleep_n = 0; step(S);
        check("R4 not yet asleep", state, 1);
        step(1);
        check("R4 asleep", state, 2);
        check("R5 clk_en off", clk_en, 0);
        check("R5 pll kept", pll_keep, 1);
        irq = 1; snoop = 1; step(1); irq = 0; snoop = 0;
        check("R6 irq masked in sleep", irq_take, 0);
        check("R6 snoop masked in sleep", snoop_take, 0);
        stopgnt = 0; step(4);
        check("R7 stop-grant drop ignored in sleep", state, 2);
        sleep_n = 1; step(S + 1);
        check("R7 wake to stop-grant", state, 1);
        check("R7 clocks restarted", clk_en, 1);
        step(1);
        check("R8 return to run", state, 0);
        // Priority: sleep already synchronised when stop-grant drops.
        sleep_n = 0; step(S + 1);
        stopgnt = 1; step(1);
        check("R2 stop-grant with sleep held", state, 1);
        stopgnt = 0; step(1);
        check("R8 sleep wins over run", state, 2);
        // Reset from sleep.
        rst_n = 0; step(1);
        check("R1 reset from sleep state", state, 0);
        check("R1 reset from sleep clk_en", clk_en, 1);
        check("R9 clk_en follows state", clk_en, state != 2);
        sleep_n = 1; step(S + 1); rst_n = 1; step(2);
        check("R1 idle after reset", state, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule